// File: doc/BRIEF.md
# Two-Phase Bus Master Controller

This block sits between an internal requester and a synchronous, unidirectional system bus. It turns each accepted request into a two-phase transaction. In the start phase it drives the address, direction and write data together with a one-cycle active-low start strobe. The block then waits as long as needed for the slave to assert acknowledge. Write data stays on the bus up to and including the acknowledge cycle. Read data is taken on the edge where acknowledge is sampled high. The requester sees one response pulse per transfer, carrying a status and the read data.

A request flagged as an internal memory hit still produces its start cycle, but the active-low kill line is asserted alongside the strobe. The external access is then void and the master is idle one cycle later. An optional watchdog of programmable length ends a transfer that is never acknowledged. Two sideband outputs carry no handshake. A registered active-low freeze line reports that the core is halted. A registered 2-bit arbiter-mode field is copied from bits [17:16] of a control word, and it can serve as general-purpose outputs when no arbiter is fitted.

Top module: `bm2p_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it: bus_start_no=1, bus_kill_no=1, req_ready_o=1, rsp_valid_o=0, freeze_no=1, arb_mode_o=0.
- R2: A request is accepted on a rising edge where req_valid_i and req_ready_o are both high. In the following cycle, and only that cycle, bus_start_no is 0. In that same cycle bus_addr_o equals the request address, bus_write_o equals the request direction (1 = write), and bus_wdata_o equals the request write data when writing.
- R3: After a start cycle that is not killed, req_ready_o stays 0 and bus_addr_o, bus_write_o and bus_wdata_o stay constant until acknowledge is sampled. The block adds one wait cycle for each cycle that bus_ack_i is low. An acknowledge in the start cycle is ignored.
- R4: When bus_ack_i is sampled high in a wait cycle, the next cycle has rsp_valid_o=1, rsp_status_o=2'b00 (OK) and req_ready_o=1. For reads, rsp_rdata_o equals bus_rdata_i at that edge.
- R5: A request with req_hit_i=1 drives bus_kill_no=0 in its start cycle. The next cycle has rsp_valid_o=1 and rsp_status_o=2'b01 (KILL), with no wait cycles. An acknowledge arriving after that produces no response.
- R6: bus_kill_no is 0 only in a cycle in which bus_start_no is 0.
- R7: With tmo_limit_i=L>0, a transfer not acknowledged in its first L wait cycles ends with rsp_status_o=2'b10 (TMO) in the cycle after wait cycle L. An acknowledge in wait cycle L takes priority and gives OK. With L=0 the master waits indefinitely.
- R8: freeze_no equals the inverse of halt_i one clock earlier.
- R9: arb_mode_o equals ctrl_i[17:16] one clock earlier. The other control bits have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request |
| req_ready_o | output | 1 | Master idle, request accepted this edge |
| req_write_i | input | 1 | Request direction, 1 = write |
| req_addr_i | input | 32 | Address of first item |
| req_wdata_i | input | 32 | Write data |
| req_hit_i | input | 1 | Internal memory hit, kill the external cycle |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_status_o | output | 2 | 00 OK, 01 KILL, 10 TMO |
| rsp_rdata_o | output | 32 | Captured read data |
| tmo_limit_i | input | 8 | Wait-cycle limit, 0 disables |
| bus_addr_o | output | 32 | Bus address |
| bus_write_o | output | 1 | Bus direction while busy |
| bus_wdata_o | output | 32 | Bus write data |
| bus_rdata_i | input | 32 | Bus read data |
| bus_start_no | output | 1 | Transfer start strobe, active low |
| bus_kill_no | output | 1 | Kill qualifier, active low |
| bus_ack_i | input | 1 | Slave acknowledge |
| halt_i | input | 1 | Core halted |
| ctrl_i | input | 32 | Control word, bits [17:16] feed arb_mode_o |
| freeze_no | output | 1 | Halt indication, active low |
| arb_mode_o | output | 2 | Arbiter mode / general-purpose outputs |

## Verification
Two pairs of events can fall in the same cycle, and the bench drives both. The first pair is acknowledge and timeout expiry: the bench sweeps the acknowledge delay across the watchdog limit, so in one case acknowledge arrives exactly in the last permitted wait cycle, and it expects OK there and TMO one cycle later. The second pair is kill and acknowledge: the bench drives acknowledge during the start cycle of killed and unkilled transfers, and again in the idle cycle after a kill. It expects KILL or a continued wait, and never a second response.

// File: rtl/bm2p_pkg.sv
package bm2p_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_START = 2'd1, ST_WAIT = 2'd2} state_e;
  typedef enum logic [1:0] {RSP_OK = 2'b00, RSP_KILL = 2'b01, RSP_TMO = 2'b10} rsp_e;
endpackage

// File: rtl/bm2p_timeout.sv
module bm2p_timeout
  import bm2p_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  state_e        state_i,
  input  logic          ack_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;
  logic          enabled;

  assign enabled  = (limit_i != '0);
  assign expire_o = (state_i == ST_WAIT) && enabled && !ack_i &&
                    (cnt_q == limit_i - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (state_i != ST_WAIT) cnt_q <= '0;
    else                         cnt_q <= cnt_q + TW'(1);
  end

  // R7 (limit held stable during a transfer)
  tmo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT && enabled) |-> (cnt_q < limit_i));
endmodule

// File: rtl/bm2p_side.sv
module bm2p_side #(
  parameter int CW      = 32,
  parameter int ARB_LSB = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          halt_i,
  input  logic [CW-1:0] ctrl_i,
  output logic          freeze_no,
  output logic [1:0]    arb_mode_o
);
  localparam int ArbMsb = ARB_LSB + 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freeze_no  <= 1'b1;
      arb_mode_o <= 2'b00;
    end else begin
      freeze_no  <= !halt_i;
      arb_mode_o <= ctrl_i[ArbMsb:ARB_LSB];
    end
  end
endmodule

// File: rtl/bm2p_seq.sv
module bm2p_seq
  import bm2p_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          req_hit_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          expire_i,
  output logic          req_ready_o,
  output state_e        state_o,
  output logic [AW-1:0] addr_o,
  output logic          write_o,
  output logic [DW-1:0] wdata_o,
  output logic          hit_o,
  output logic          rsp_valid_o,
  output logic [1:0]    rsp_status_o,
  output logic [DW-1:0] rsp_rdata_o
);
  state_e        state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          write_q, hit_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign state_o     = state_q;
  assign addr_o      = addr_q;
  assign wdata_o     = wdata_q;
  assign hit_o       = hit_q;
  assign write_o     = write_q && (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      wdata_q      <= '0;
      write_q      <= 1'b0;
      hit_q        <= 1'b0;
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= RSP_OK;
      rsp_rdata_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          write_q <= req_write_i;
          hit_q   <= req_hit_i;
          state_q <= ST_START;
        end
        ST_START: begin
          // ack in the start phase is not part of the handshake
          if (hit_q) begin
            state_q      <= ST_IDLE;
            rsp_valid_o  <= 1'b1;
            rsp_status_o <= RSP_KILL;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ack_i) begin
            state_q      <= ST_IDLE;
            rsp_valid_o  <= 1'b1;
            rsp_status_o <= RSP_OK;
            rsp_rdata_o  <= rdata_i;
          end else if (expire_i) begin
            state_q      <= ST_IDLE;
            rsp_valid_o  <= 1'b1;
            rsp_status_o <= RSP_TMO;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START) |=> (state_q != ST_START));
  // R3
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !ack_i && !expire_i) |=>
      (state_q == ST_WAIT && !rsp_valid_o && $stable(addr_o) && $stable(wdata_o)));
  // R4
  ack_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && ack_i) |=>
      (rsp_valid_o && rsp_status_o == RSP_OK && rsp_rdata_o == $past(rdata_i) && req_ready_o));
  // R5
  kill_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && hit_q) |=>
      (state_q == ST_IDLE && rsp_valid_o && rsp_status_o == RSP_KILL));
endmodule

// File: rtl/bm2p_master.sv
module bm2p_master
  import bm2p_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int TW      = 8,
  parameter int CW      = 32,
  parameter int ARB_LSB = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          req_hit_i,
  output logic          rsp_valid_o,
  output logic [1:0]    rsp_status_o,
  output logic [DW-1:0] rsp_rdata_o,
  input  logic [TW-1:0] tmo_limit_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_write_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_start_no,
  output logic          bus_kill_no,
  input  logic          bus_ack_i,
  input  logic          halt_i,
  input  logic [CW-1:0] ctrl_i,
  output logic          freeze_no,
  output logic [1:0]    arb_mode_o
);
  state_e state;
  logic   hit, expire;

  bm2p_seq #(.AW(AW), .DW(DW)) seq_i (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i, .req_hit_i,
    .ack_i(bus_ack_i), .rdata_i(bus_rdata_i), .expire_i(expire),
    .req_ready_o, .state_o(state),
    .addr_o(bus_addr_o), .write_o(bus_write_o), .wdata_o(bus_wdata_o),
    .hit_o(hit),
    .rsp_valid_o, .rsp_status_o, .rsp_rdata_o
  );

  bm2p_timeout #(.TW(TW)) tmo_i (
    .clk_i, .rst_ni, .state_i(state), .ack_i(bus_ack_i),
    .limit_i(tmo_limit_i), .expire_o(expire)
  );

  bm2p_side #(.CW(CW), .ARB_LSB(ARB_LSB)) side_i (
    .clk_i, .rst_ni, .halt_i, .ctrl_i, .freeze_no, .arb_mode_o
  );

  assign bus_start_no = !(state == ST_START);
  assign bus_kill_no  = !(state == ST_START && hit);

  // R6
  kill_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_kill_no |-> !bus_start_no);
  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_start_no |=> bus_start_no);
  // R3
  busy_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_start_no && bus_kill_no) |=> (!req_ready_o && !rsp_valid_o));
endmodule

// File: tb/bm2p_master_tb_top.sv
module bm2p_master_tb_top;
  localparam int AW = 32, DW = 32, TW = 8, CW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_hit = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_rdata = '0;
  logic [TW-1:0] tmo_limit = '0;
  logic          bus_ack = 0, halt = 0;
  logic [CW-1:0] ctrl = '0;
  logic          req_ready, rsp_valid, bus_write, bus_start_n, bus_kill_n, freeze_n;
  logic [1:0]    rsp_status, arb_mode;
  logic [DW-1:0] rsp_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;

  int checks = 0, errors = 0;

  bm2p_master dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_hit_i(req_hit),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_rdata_o(rsp_rdata),
    .tmo_limit_i(tmo_limit),
    .bus_addr_o(bus_addr), .bus_write_o(bus_write), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_start_no(bus_start_n), .bus_kill_no(bus_kill_n),
    .bus_ack_i(bus_ack), .halt_i(halt), .ctrl_i(ctrl),
    .freeze_no(freeze_n), .arb_mode_o(arb_mode)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic xfer(input bit wr, input bit hit, input int d, input bit ack_start,
                      input logic [TW-1:0] lim, input int seed);
    logic [AW-1:0] a;
    logic [DW-1:0] wd, rd;
    a  = 32'h1000_0000 + AW'(seed * 32'h0001_0104);
    wd = 32'hA5A5_0000 ^ DW'(seed * 32'h0003_1011);
    rd = 32'h5A5A_0000 ^ DW'(seed * 32'h0007_2023);
    tmo_limit = lim;
    chk("R2 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1; req_write = wr; req_hit = hit; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~wd;
    chk("R2 start low", 64'(bus_start_n), 64'd0);
    chk("R2 address", 64'(bus_addr), 64'(a));
    chk("R2 direction", 64'(bus_write), 64'(wr));
    if (wr) chk("R2 write data", 64'(bus_wdata), 64'(wd));
    chk("R5 kill in start", 64'(bus_kill_n), 64'(!hit));
    if (ack_start) begin bus_ack = 1; bus_rdata = ~rd; end
    @(negedge clk);
    bus_ack = 0;
    chk("R2 start single cycle", 64'(bus_start_n), 64'd1);
    chk("R6 kill only with start", 64'(bus_kill_n), 64'd1);
    if (hit) begin
      chk("R5 kill response", 64'(rsp_valid), 64'd1);
      chk("R5 kill status", 64'(rsp_status), 64'b01);
      chk("R5 idle after kill", 64'(req_ready), 64'd1);
      bus_ack = 1;
      @(negedge clk);
      bus_ack = 0;
      chk("R5 late ack ignored", 64'(rsp_valid), 64'd0);
      chk("R5 still idle", 64'(req_ready), 64'd1);
      return;
    end
    for (int k = 0; k < 64; k++) begin
      if (k == d) begin bus_ack = 1; bus_rdata = rd; end
      chk("R3 busy while waiting", 64'(req_ready), 64'd0);
      chk("R3 no response while waiting", 64'(rsp_valid), 64'd0);
      chk("R3 address held", 64'(bus_addr), 64'(a));
      if (wr) chk("R3 write data held", 64'(bus_wdata), 64'(wd));
      @(negedge clk);
      bus_ack = 0;
      if (k == d) begin
        chk("R4 response", 64'(rsp_valid), 64'd1);
        chk("R4 OK status", 64'(rsp_status), 64'b00);
        chk("R4 ready", 64'(req_ready), 64'd1);
        if (!wr) chk("R4 read data", 64'(rsp_rdata), 64'(rd));
        break;
      end
      if (lim != 0 && k == int'(lim) - 1) begin
        chk("R7 timeout response", 64'(rsp_valid), 64'd1);
        chk("R7 TMO status", 64'(rsp_status), 64'b10);
        chk("R7 ready", 64'(req_ready), 64'd1);
        break;
      end
    end
    @(negedge clk);
    chk("R4 single response pulse", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    int seed;
    seed = 0;
    #1;
    chk("R1 start in reset", 64'(bus_start_n), 64'd1);
    chk("R1 kill in reset", 64'(bus_kill_n), 64'd1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 rsp", 64'(rsp_valid), 64'd0);
    chk("R1 freeze", 64'(freeze_n), 64'd1);
    chk("R1 arb", 64'(arb_mode), 64'd0);
    chk("R1 start", 64'(bus_start_n), 64'd1);
    chk("R1 kill", 64'(bus_kill_n), 64'd1);
    // ack while idle must not start anything
    bus_ack = 1;
    @(negedge clk);
    bus_ack = 0;
    chk("R3 idle ack ignored", 64'(rsp_valid), 64'd0);
    for (int li = 0; li < 3; li++)
      for (int wr = 0; wr < 2; wr++)
        for (int hit = 0; hit < 2; hit++)
          for (int as = 0; as < 2; as++)
            for (int d = 0; d < 7; d++) begin
              logic [TW-1:0] lim;
              lim = (li == 0) ? TW'(0) : (li == 1) ? TW'(1) : TW'(3);
              seed++;
              xfer(wr[0], hit[0], d, as[0], lim, seed);
            end
    // sideband sweep: R8, R9
    for (int i = 0; i < 32; i++) begin
      logic h;
      logic [CW-1:0] c;
      h = i[0] ^ i[3];
      c = (CW'(i) * 32'h9E37_79B1) ^ CW'(i << 16);
      halt = h; ctrl = c;
      @(negedge clk);
      chk("R8 freeze follows halt", 64'(freeze_n), 64'(!h));
      chk("R9 arb mode bits", 64'(arb_mode), 64'(c[17:16]));
    end
    // R9: other control bits do not move the field
    ctrl = 32'h0002_0000;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ctrl = 32'h0002_0000 | (CW'(i) * 32'h1234_5679 & ~32'h0003_0000);
      @(negedge clk);
      chk("R9 unrelated bits no effect", 64'(arb_mode), 64'b10);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule